// File: doc/BRIEF.md
# Chained Debug Watchpoint Pair

This block watches a processor bus (address, data and an 8-bit control word) with two watchpoint units and raises a debug break request. Each unit holds a value and a mask for address, data and control. A set mask bit removes the matching bit from the comparison. A unit matches when every unmasked bit agrees with its value register and each qualifier it selects is satisfied. The block's break request is the registered OR of the units' enabled matches.

Unit 1 can qualify unit 0 in two ways. The first is a chain flag. Unit 1 stores this flag whenever its address and control comparison hits, and the stored value is unit 1's data comparison result. This lets unit 0 fire only after an earlier bus event. The second is a range signal, which is unit 1's full match in the current cycle. This lets unit 0 fire only when both units match at once. Each unit also has an external condition input that it can select as a further qualifier.

Configuration uses a write-only register port. Bit 3 of the register address selects the unit. Bits [2:0] select the register within the unit: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Indices 6 and 7 are not decoded. In the control value register, bits [7:0] are the compare value, bit 8 enables the break, bit 9 selects the chain qualifier, bit 10 selects the range qualifier and bit 11 selects the external qualifier. The control mask uses bits [7:0] only. To break on a 32-bit instruction fetch, write the fetch address with address mask 0x3. For a 16-bit instruction fetch, use address mask 0x1.

Top module: `dwp_pair`

## Requirements
- R1: After reset, all value and mask registers are zero and `brk_req_o` is low, so an all-zero bus does not cause a break.
- R2: A set bit of a unit's address mask excludes that address bit from the comparison. With mask 0x3, every address sharing bits [31:2] with the value matches. With mask 0x1, only bit 0 is ignored.
- R3: A set bit of a unit's data mask excludes that data bit from the comparison. Any unmasked difference prevents a match.
- R4: Control bits [7:0] are compared against control value bits [7:0]. A set bit in control mask bits [7:0] excludes that control bit.
- R5: A match raises the break only when enable bit 8 of the control value is set. No mask setting can stand in for that bit.
- R6: When control value bit 11 is set, unit n matches only while `ext_cond_i[n]` is high.
- R7: While unit 1's unmasked address and control bits agree, the chain flag is loaded each cycle with unit 1's data comparison result. Otherwise it holds. When control value bit 9 is set, unit 0 matches only while the chain flag is set.
- R8: A write to unit 1's control value register clears the chain flag, taking precedence over a load in the same cycle. The chain flag is also cleared by reset.
- R9: When control value bit 10 is set, unit 0 matches only in cycles where unit 1 fully matches. Unit 1's enable bit has no effect on this.
- R10: `brk_req_o` is the OR of both units' enabled matches, registered once. It goes high in the cycle after the matching bus cycle.
- R11: On unit 1, control value bits 9 and 10 have no effect on its match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 32 | Watched bus address |
| bus_data_i | input | 32 | Watched bus data |
| bus_ctrl_i | input | 8 | Watched bus control word |
| ext_cond_i | input | 2 | External condition, bit n for unit n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: bit 3 unit, bits [2:0] index |
| reg_wdata_i | input | 32 | Register write data |
| brk_req_o | output | 1 | Registered break request, active high |

## Verification
The assertions check four things on every cycle:
- An enabled match always produces a break in the next cycle.
- No break appears while both enable bits are clear.
- The chain flag changes only on a unit 1 address/control hit or a control write, and a control write clears it.
- Unit 0 never reports an enabled match while a selected chain or range qualifier is false.

The bench's scenarios show the rest:
- The mask semantics for each field.
- The instruction-breakpoint masks.
- The external qualifier per unit.
- The ordering of a chained event followed by the dependent access.
- The exact one-cycle latency of the break request.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned CTRL_W = 8;
  parameter int unsigned REG_AW = 4;
  parameter int unsigned REG_DW = 32;

  localparam int unsigned IDX_W     = 3;
  localparam int unsigned CFG_W     = CTRL_W + 4;
  localparam int unsigned EN_BIT    = CTRL_W;
  localparam int unsigned CHAIN_BIT = CTRL_W + 1;
  localparam int unsigned RANGE_BIT = CTRL_W + 2;
  localparam int unsigned EXT_BIT   = CTRL_W + 3;
  localparam int unsigned N_UNITS   = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_AVAL = 3'd0,
    IDX_AMSK = 3'd1,
    IDX_DVAL = 3'd2,
    IDX_DMSK = 3'd3,
    IDX_CVAL = 3'd4,
    IDX_CMSK = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic [ADDR_W-1:0] a_val;
    logic [ADDR_W-1:0] a_msk;
    logic [DATA_W-1:0] d_val;
    logic [DATA_W-1:0] d_msk;
    logic [CFG_W-1:0]  c_val;
    logic [CTRL_W-1:0] c_msk;
  } wp_cfg_t;
endpackage

// File: rtl/dwp_regs.sv
module dwp_regs
  import dwp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output wp_cfg_t           cfg0_o,
  output wp_cfg_t           cfg1_o,
  output logic [N_UNITS-1:0] cval_wr_o
);
  wp_cfg_t cfg_q [N_UNITS];

  logic       unit_sel;
  reg_idx_e   idx;
  logic       unused_wdata;

  assign unit_sel     = addr_i[IDX_W];
  assign idx          = reg_idx_e'(addr_i[IDX_W-1:0]);
  assign unused_wdata = ^wdata_i;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic hit;
    assign hit          = we_i && (unit_sel == 1'(u));
    assign cval_wr_o[u] = hit && (idx == IDX_CVAL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[u] <= '0;
      end else if (hit) begin
        unique case (idx)
          IDX_AVAL: cfg_q[u].a_val <= wdata_i[ADDR_W-1:0];
          IDX_AMSK: cfg_q[u].a_msk <= wdata_i[ADDR_W-1:0];
          IDX_DVAL: cfg_q[u].d_val <= wdata_i[DATA_W-1:0];
          IDX_DMSK: cfg_q[u].d_msk <= wdata_i[DATA_W-1:0];
          IDX_CVAL: cfg_q[u].c_val <= wdata_i[CFG_W-1:0];
          IDX_CMSK: cfg_q[u].c_msk <= wdata_i[CTRL_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign cfg0_o = cfg_q[0];
  assign cfg1_o = cfg_q[1];
endmodule

// File: rtl/dwp_unit.sv
module dwp_unit
  import dwp_pkg::*;
#(
  parameter bit LINK_IN   = 1'b0,
  parameter bit CHAIN_OUT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wp_cfg_t           cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ext_i,
  input  logic              chain_i,
  input  logic              range_i,
  input  logic              cval_wr_i,
  output logic              match_o,
  output logic              hit_o,
  output logic              ac_hit_o,
  output logic              chain_o
);
  logic addr_eq, data_eq, ctrl_eq;
  logic q_ext, q_chain, q_range;

  assign addr_eq  = ~|((addr_i ^ cfg_i.a_val) & ~cfg_i.a_msk);
  assign data_eq  = ~|((data_i ^ cfg_i.d_val) & ~cfg_i.d_msk);
  assign ctrl_eq  = ~|((ctrl_i ^ cfg_i.c_val[CTRL_W-1:0]) & ~cfg_i.c_msk);
  assign ac_hit_o = addr_eq && ctrl_eq;

  assign q_ext = !cfg_i.c_val[EXT_BIT] || ext_i;

  if (LINK_IN) begin : g_link
    assign q_chain = !cfg_i.c_val[CHAIN_BIT] || chain_i;
    assign q_range = !cfg_i.c_val[RANGE_BIT] || range_i;
  end else begin : g_nolink
    logic unused_link;
    assign unused_link = chain_i ^ range_i;
    assign q_chain     = 1'b1;
    assign q_range     = 1'b1;
  end

  assign match_o = addr_eq && data_eq && ctrl_eq && q_ext && q_chain && q_range;
  assign hit_o   = match_o && cfg_i.c_val[EN_BIT];

  if (CHAIN_OUT) begin : g_chain
    logic chain_q;
    // control write clear outranks a load in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        chain_q <= 1'b0;
      else if (cval_wr_i) chain_q <= 1'b0;
      else if (ac_hit_o)  chain_q <= data_eq;
    end
    assign chain_o = chain_q;
  end else begin : g_nochain
    logic unused_chain;
    assign unused_chain = clk_i ^ rst_ni ^ cval_wr_i;
    assign chain_o      = 1'b0;
  end
endmodule

// File: rtl/dwp_pair.sv
module dwp_pair
  import dwp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [CTRL_W-1:0] bus_ctrl_i,
  input  logic [1:0]        ext_cond_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic              brk_req_o
);
  wp_cfg_t             cfg0, cfg1;
  logic [N_UNITS-1:0]  cval_wr;
  logic [N_UNITS-1:0]  unit_hit;
  logic                match0, match1;
  logic                ac_hit0, ac_hit1;
  logic                chain_q;
  logic                chain_unused;
  logic                brk_q;

  dwp_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cfg0_o    (cfg0),
    .cfg1_o    (cfg1),
    .cval_wr_o (cval_wr)
  );

  // unit 1 feeds chain and range into unit 0
  dwp_unit #(.LINK_IN(1'b0), .CHAIN_OUT(1'b1)) u_wp1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg1),
    .addr_i    (bus_addr_i),
    .data_i    (bus_data_i),
    .ctrl_i    (bus_ctrl_i),
    .ext_i     (ext_cond_i[1]),
    .chain_i   (1'b0),
    .range_i   (1'b0),
    .cval_wr_i (cval_wr[1]),
    .match_o   (match1),
    .hit_o     (unit_hit[1]),
    .ac_hit_o  (ac_hit1),
    .chain_o   (chain_q)
  );

  dwp_unit #(.LINK_IN(1'b1), .CHAIN_OUT(1'b0)) u_wp0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg0),
    .addr_i    (bus_addr_i),
    .data_i    (bus_data_i),
    .ctrl_i    (bus_ctrl_i),
    .ext_i     (ext_cond_i[0]),
    .chain_i   (chain_q),
    .range_i   (match1),
    .cval_wr_i (cval_wr[0]),
    .match_o   (match0),
    .hit_o     (unit_hit[0]),
    .ac_hit_o  (ac_hit0),
    .chain_o   (chain_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= |unit_hit;
  end

  assign brk_req_o = brk_q;
endmodule

// File: rtl/dwp_chk.sv
module dwp_chk
  import dwp_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               brk_req_o,
  input logic [N_UNITS-1:0] unit_hit,
  input logic [N_UNITS-1:0] cval_wr,
  input logic               match1,
  input logic               ac_hit1,
  input logic               chain_q,
  input wp_cfg_t            cfg0,
  input wp_cfg_t            cfg1
);
  // R10
  hit_to_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unit_hit) |=> brk_req_o);

  // R5
  no_enable_no_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg0.c_val[EN_BIT] && !cfg1.c_val[EN_BIT]) |=> !brk_req_o);

  // R8
  chain_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cval_wr[1] |=> !chain_q);

  // R7
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ac_hit1 && !cval_wr[1]) |=> $stable(chain_q));

  // R7
  chain_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_hit[0] && cfg0.c_val[CHAIN_BIT]) |-> chain_q);

  // R9
  range_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_hit[0] && cfg0.c_val[RANGE_BIT]) |-> match1);
endmodule

bind dwp_pair dwp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .brk_req_o (brk_req_o),
  .unit_hit  (unit_hit),
  .cval_wr   (cval_wr),
  .match1    (match1),
  .ac_hit1   (ac_hit1),
  .chain_q   (chain_q),
  .cfg0      (cfg0),
  .cfg1      (cfg1)
);

// File: tb/sim_dwp_pair.sv
`timescale 1ns/1ps
module sim_dwp_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0, data = '0;
  logic [7:0]  ctrl = '0;
  logic [1:0]  ext = '0;
  logic        we = 1'b0;
  logic [3:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic        brk;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dwp_pair u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_data_i(data),
    .bus_ctrl_i(ctrl), .ext_cond_i(ext), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .brk_req_o(brk)
  );

  localparam logic [31:0] EN = 32'h100, CH = 32'h200, RG = 32'h400, EX = 32'h800;
  localparam logic [31:0] IDLE = 32'hFFFF_FF00;

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: brk_req_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int u, input int idx, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = 4'(u * 8 + idx); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // drive one bus cycle at a negedge, return at the negedge after the capturing edge
  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic [7:0] c,
                     input logic [1:0] e);
    addr = a; data = d; ctrl = c; ext = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus;
    cyc(IDLE, 32'h0, 8'h00, 2'b00);
  endtask

  task automatic clear_all;
    idle_bus();
    for (int u = 0; u < 2; u++)
      for (int i = 0; i < 6; i++) wr(u, i, 32'h0);
  endtask

  // unit fully masked except address, with given control value
  task automatic addr_only(input int u, input logic [31:0] a, input logic [31:0] am,
                           input logic [31:0] cv);
    wr(u, 0, a); wr(u, 1, am); wr(u, 3, 32'hFFFF_FFFF); wr(u, 5, 32'hFF); wr(u, 4, cv);
  endtask

  task automatic t_reset;
    cyc(32'h0, 32'h0, 8'h00, 2'b00);
    check("R1 zero bus after reset", brk, 1'b0);
  endtask

  task automatic t_addr;
    clear_all();
    addr_only(0, 32'h1000, 32'h3, EN);
    cyc(32'h1002, 32'h0, 8'h0, 2'b00); check("R2 word mask inside", brk, 1'b1);
    cyc(32'h1004, 32'h0, 8'h0, 2'b00); check("R2 word mask outside", brk, 1'b0);
    wr(0, 1, 32'h1);
    cyc(32'h1001, 32'h0, 8'h0, 2'b00); check("R2 half mask inside", brk, 1'b1);
    cyc(32'h1002, 32'h0, 8'h0, 2'b00); check("R2 half mask outside", brk, 1'b0);
  endtask

  task automatic t_data;
    clear_all();
    wr(0, 1, 32'hFFFF_FFFF); wr(0, 2, 32'hDEAD_0000); wr(0, 3, 32'h0000_FFFF);
    wr(0, 5, 32'hFF); wr(0, 4, EN);
    cyc(32'h0, 32'hDEAD_1234, 8'h0, 2'b00); check("R3 data masked low", brk, 1'b1);
    cyc(32'h0, 32'hDEAC_0000, 8'h0, 2'b00); check("R3 data mismatch", brk, 1'b0);
  endtask

  task automatic t_ctrl;
    clear_all();
    wr(0, 1, 32'hFFFF_FFFF); wr(0, 3, 32'hFFFF_FFFF);
    wr(0, 5, 32'h0F); wr(0, 4, EN | 32'h5A);
    cyc(32'h0, 32'h0, 8'h53, 2'b00); check("R4 ctrl masked nibble", brk, 1'b1);
    cyc(32'h0, 32'h0, 8'h6A, 2'b00); check("R4 ctrl mismatch", brk, 1'b0);
  endtask

  task automatic t_enable;
    clear_all();
    wr(0, 1, 32'hFFFF_FFFF); wr(0, 3, 32'hFFFF_FFFF); wr(0, 5, 32'hFFFF_FFFF);
    wr(0, 4, 32'h0);
    cyc(32'h0, 32'h0, 8'h00, 2'b00); check("R5 all masked no enable", brk, 1'b0);
  endtask

  task automatic t_ext;
    clear_all();
    addr_only(1, 32'h0, 32'hFFFF_FFFF, EN | EX);
    cyc(32'h0, 32'h0, 8'h0, 2'b10); check("R6 unit1 ext high", brk, 1'b1);
    cyc(32'h0, 32'h0, 8'h0, 2'b01); check("R6 unit1 ext low", brk, 1'b0);
  endtask

  task automatic t_chain;
    clear_all();
    wr(1, 0, 32'h100); wr(1, 2, 32'hAA); wr(1, 5, 32'hFF); wr(1, 4, 32'h0);
    addr_only(0, 32'h200, 32'h0, EN | CH);
    cyc(32'h200, 32'h0, 8'h0, 2'b00); check("R7 no prior event", brk, 1'b0);
    cyc(32'h100, 32'hAA, 8'h0, 2'b00); check("R7 event cycle", brk, 1'b0);
    cyc(32'h200, 32'h0, 8'h0, 2'b00); check("R7 chained access", brk, 1'b1);
    cyc(32'h300, 32'h0, 8'h0, 2'b00);
    cyc(32'h200, 32'h0, 8'h0, 2'b00); check("R7 chain holds", brk, 1'b1);
    cyc(32'h100, 32'h55, 8'h0, 2'b00);
    cyc(32'h200, 32'h0, 8'h0, 2'b00); check("R7 data miss reloads", brk, 1'b0);
    cyc(32'h100, 32'hAA, 8'h0, 2'b00);
    wr(1, 4, 32'h0);
    cyc(32'h200, 32'h0, 8'h0, 2'b00); check("R8 ctrl write clears chain", brk, 1'b0);
  endtask

  task automatic t_range;
    clear_all();
    addr_only(1, 32'h40, 32'h0, 32'h0);
    addr_only(0, 32'h0, 32'hFFFF_FFFF, EN | RG);
    cyc(32'h40, 32'h0, 8'h0, 2'b00); check("R9 both match", brk, 1'b1);
    cyc(32'h44, 32'h0, 8'h0, 2'b00); check("R9 unit1 misses", brk, 1'b0);
  endtask

  task automatic t_unit1_sel;
    clear_all();
    addr_only(1, 32'h0, 32'hFFFF_FFFF, EN | CH | RG);
    cyc(32'h0, 32'h0, 8'h0, 2'b00); check("R11 unit1 ignores selects", brk, 1'b1);
  endtask

  task automatic t_or_latency;
    clear_all();
    addr_only(0, 32'hA0, 32'h0, EN);
    addr_only(1, 32'hB0, 32'h0, EN);
    cyc(32'hA0, 32'h0, 8'h0, 2'b00); check("R10 unit0 alone", brk, 1'b1);
    cyc(32'hB0, 32'h0, 8'h0, 2'b00); check("R10 unit1 alone", brk, 1'b1);
    cyc(32'hC0, 32'h0, 8'h0, 2'b00); check("R10 neither", brk, 1'b0);
    addr = 32'hA0;
    #2 check("R10 not before edge", brk, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10 one cycle later", brk, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 brk low in reset", brk, 1'b0);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_data();
    t_ctrl();
    t_enable();
    t_ext();
    t_chain();
    t_range();
    t_unit1_sel();
    t_or_latency();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run ended early, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule